// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block lets an on-chip requester read and write a 128K x 8 asynchronous static RAM through its parallel pins. The requester presents a request with a valid/ready handshake, a write flag, a 17-bit word address and an 8-bit write word. Reads return an 8-bit word with a single-cycle valid strobe.

On the memory side the controller drives the address bus and four strobes: an active-low chip select, an active-high chip select, an active-low output enable and an active-low write enable. The bidirectional data bus is split into a driven word, a driver enable and a sampled input word. A pad ring joins these three signals onto the real pins.

All memory timing comes from counting clock cycles. The counts are worked out at elaboration from the clock period and the memory's nanosecond limits. Each count is ceil(ns / period), with a minimum of one cycle. Writes are always ended by the write enable. The output enable stays high for the whole write, so the memory never drives the bus while the controller does.

Top module: `sram_port_ctrl`

## Requirements
- R1: While idle, and from reset, `req_ready` is 1, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dout_oe`=0 and `rd_valid`=0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the operation completes, and requests presented during that time are ignored.
- R3: While an operation is busy, `mem_addr` holds the accepted address unchanged, and both chip selects are asserted (`mem_ce_n`=0, `mem_ce`=1).
- R4: A read holds `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC = max(1, ceil(T_AA_NS/CLK_NS)) cycles. That is 2 cycles at the defaults, so `req_ready` is low for exactly RD_CYC cycles.
- R5: A read samples `mem_din` on its last access edge. In the following cycle it shows that word on `rd_data` with `rd_valid`=1 for exactly one cycle. `rd_valid` is never raised by a write.
- R6: A write first spends SU_CYC = max(1, ceil(T_HZ_NS/CLK_NS)) cycles selected with `mem_we_n`=1 and the drivers off.
- R7: After that set-up phase, `mem_we_n` is held low for WE_CYC = max(1, ceil(max(T_PWE_NS, T_SD_NS)/CLK_NS)) cycles. `mem_dout_oe`=1 and `mem_dout` holds the write word throughout.
- R8: After `mem_we_n` rises, the write data and chip selects stay asserted for one more cycle. At the defaults the write keeps `req_ready` low for SU_CYC+WE_CYC+1 = 4 cycles, and the word is stored at the accepted address.
- R9: `mem_oe_n` is 1 whenever `mem_we_n` is 0. `mem_dout_oe` is 1 only when `mem_oe_n` was also 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (17) | Word address |
| req_wdata | input | DW (8) | Write word |
| rd_data | output | DW (8) | Read word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_addr | output | AW (17) | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dout | output | DW (8) | Data to drive on the bus |
| mem_dout_oe | output | 1 | Bus driver enable |
| mem_din | input | DW (8) | Data sampled from the bus |

## Verification
The bench's memory model returns a poison word on any read sampled sooner than the access time after the address or strobes last changed. A controller that samples one cycle early therefore returns the wrong data. Write pulses are timed in nanoseconds at each rising write enable. A pulse that is too short, or that has no set-up gap after select, is reported even when the data happens to land.

A request kept valid through a busy write with a changed address would create a phantom second write if it were accepted. The bench reads that address back to catch this. Back-to-back operations at addresses zero and all-ones, and write-then-read of the same word, show whether the handshake or address register is off by one.

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl #(
  parameter int CLK_NS   = 8,
  parameter int T_AA_NS  = 15,
  parameter int T_PWE_NS = 12,
  parameter int T_SD_NS  = 8,
  parameter int T_HZ_NS  = 7,
  parameter int AW       = 17,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_oe,
  input  logic [DW-1:0] mem_din
);
  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC = to_cyc(T_AA_NS);
  localparam int WE_CYC = to_cyc((T_PWE_NS > T_SD_NS) ? T_PWE_NS : T_SD_NS);
  localparam int SU_CYC = to_cyc(T_HZ_NS);
  localparam int MAX_A  = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int MAX_C  = (MAX_A > SU_CYC) ? MAX_A : SU_CYC;
  localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WSU, S_WPUL, S_WHLD} st_t;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          st      <= req_write ? S_WSU : S_READ;
        end
        S_READ: if (cnt == CW'(RD_CYC - 1)) begin
          rd_data  <= mem_din;
          rd_valid <= 1'b1;
          st       <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WSU: if (cnt == CW'(SU_CYC - 1)) begin
          cnt <= '0;
          st  <= S_WPUL;
        end else cnt <= cnt + 1'b1;
        S_WPUL: if (cnt == CW'(WE_CYC - 1)) st <= S_WHLD;
                else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign mem_addr    = addr_q;
  assign mem_ce_n    = (st == S_IDLE);
  assign mem_ce      = (st != S_IDLE);
  assign mem_oe_n    = (st != S_READ);
  assign mem_we_n    = (st != S_WPUL);
  assign mem_dout    = wdata_q;
  assign mem_dout_oe = (st == S_WPUL) || (st == S_WHLD);

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dout_oe));
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_we_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_oe |-> (mem_oe_n && $past(mem_oe_n)));
  p_drive_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dout_oe);
endmodule

// File: tb/sram_port_ctrl_tb.sv
`timescale 1ns/1ps
module sram_port_ctrl_tb;
  localparam int CLK = 8;
  localparam int RD_C = 2, SU_C = 1, WE_C = 2;

  logic clk = 0, rst_n = 0, req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0] req_wdata = '0, mem_din = 8'h5A;
  logic req_ready, rd_valid, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_oe;
  logic [7:0] rd_data, mem_dout;
  logic [16:0] mem_addr;
  int nchk = 0, nfail = 0;
  logic [7:0] mdl [int];
  logic [7:0] shd [int];
  realtime t_chg = 0, t_fall = 0, t_sel = 0;
  bit started = 0;

  always #(CLK/2) clk = ~clk;

  sram_port_ctrl u_dut (.clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr,
    .req_wdata, .rd_data, .rd_valid, .mem_addr, .mem_ce_n, .mem_ce, .mem_oe_n,
    .mem_we_n, .mem_dout, .mem_dout_oe, .mem_din);

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(mem_addr, mem_ce_n, mem_ce, mem_oe_n, mem_we_n) t_chg = $realtime;
  always @(negedge mem_ce_n) t_sel = $realtime;
  always @(negedge mem_we_n) t_fall = $realtime;
  always @(posedge mem_we_n) if (started) begin
    chk(($realtime - t_fall) >= 12.0 && ($realtime - t_fall) == WE_C*CLK, "R7 pulse ns",
        int'($realtime - t_fall), WE_C*CLK);
    chk(($realtime - t_sel) - ($realtime - t_fall) >= SU_C*CLK, "R6 setup ns",
        int'(t_fall - t_sel), SU_C*CLK);
    chk(mem_dout_oe && mem_oe_n, "R9 drive at write end", {mem_dout_oe, mem_oe_n}, 3);
    if (!mem_ce_n && mem_ce) mdl[int'(mem_addr)] = mem_dout;
  end

  initial begin
    #0.25;
    forever begin
      #1;
      if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
        mem_din = (($realtime - t_chg) >= 15.0) ?
                  (mdl.exists(int'(mem_addr)) ? mdl[int'(mem_addr)] : 8'h00) : 8'hEE;
      else mem_din = 8'h5A;
    end
  end

  bit contention = 0;
  always @(negedge clk) if (started && mem_dout_oe && !mem_oe_n) contention = 1;

  task automatic op(bit wr, logic [16:0] a, logic [7:0] d, bit hold);
    int busy;
    logic [7:0] e;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin req_addr = a ^ 17'h00155; req_wdata = ~d; req_write = 1; end
    else req_valid = 0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      chk(mem_addr == a && !mem_ce_n && mem_ce, "R3 addr/select held", int'(mem_addr), int'(a));
      chk(!rd_valid, "R5 no strobe while busy", rd_valid, 0);
      if (!wr) chk(!mem_oe_n && mem_we_n, "R4 read strobes", {mem_oe_n, mem_we_n}, 1);
      @(negedge clk);
    end
    req_valid = 0;
    if (wr) begin
      shd[int'(a)] = d;
      chk(busy == SU_C + WE_C + 1, "R8 write busy cycles", busy, SU_C + WE_C + 1);
      chk(!rd_valid, "R5 no strobe on write", rd_valid, 0);
    end else begin
      e = shd.exists(int'(a)) ? shd[int'(a)] : 8'h00;
      chk(busy == RD_C, "R4 read busy cycles", busy, RD_C);
      chk(rd_valid && rd_data == e, "R5 read data", int'(rd_data), int'(e));
      @(negedge clk);
      chk(!rd_valid, "R5 single pulse", rd_valid, 0);
    end
  endtask

  initial begin
    #(CLK * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dout_oe && !rd_valid,
        "R1 reset state", {req_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dout_oe}, 6'b110110);
    rst_n = 1;
    started = 1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_ce, "R1 idle after reset", {req_ready, mem_ce_n, mem_ce}, 3'b110);
    op(1, 17'h00000, 8'hA5, 0);
    op(1, 17'h1FFFF, 8'h3C, 0);
    op(0, 17'h00000, 8'h00, 0);
    op(0, 17'h1FFFF, 8'h00, 0);
    op(1, 17'h00100, 8'h77, 1);
    op(0, 17'h00100 ^ 17'h00155, 8'h00, 0); // R2: held request must not write
    op(0, 17'h00100, 8'h00, 0);
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      a = ($urandom % 4 == 0) ? 17'($urandom) : 17'($urandom % 16);
      op(1'($urandom), a, 8'($urandom), 0);
      if ($urandom % 3 == 0) begin
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(req_ready && mem_ce_n && !rd_valid, "R1 idle gap", {req_ready, mem_ce_n, rd_valid}, 3'b110);
        end
      end
    end
    chk(!contention, "R9 no bus contention", contention, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule